// File: doc/BRIEF.md
# Command Descriptor Ring Fetcher

This block serves one circular ring of command descriptors held in host memory. Software describes the ring through a small register set: a base address, a ring length counted in descriptors, a descriptor-format word carrying the per-descriptor byte stride, and a fetch-control word. Software then announces new work by writing how many descriptors it has just added. The block keeps a running total of announced descriptors, a total of those already fetched, and a total of those handed onward. It also keeps a fetch pointer and a processed pointer. Both pointers are ring indices that wrap at the ring length.

Whenever work is waiting and the local descriptor FIFO has enough free slots, the block issues one burst read on its DMA request port. The burst covers a block of descriptors starting at base + pointer × stride. The DMA response beats are each one descriptor wide. They are pushed into the FIFO, and the FIFO feeds a downstream parser through a valid/ready output. Only one burst is outstanding at any time. A burst never runs past the end of the ring, never exceeds the waiting count, and never exceeds the FIFO's free space.

Top module: `cdr_fetcher`

## Requirements
- R1: After a synchronous reset, no DMA request is pending and the output is not valid. All counters, both pointers and the status word read as zero.
- R2: The block issues no fetch while the fetch-control word (address 3) is zero, while its length field [15:0] is zero, or while the ring length (address 1) is zero, even when descriptors are waiting.
- R3: A fetch is issued only when the waiting count is non-zero and the FIFO's free slots are at least the threshold field [31:16] of the fetch-control word. Its length is the smallest of the length field, the waiting count, and the slots left before the ring end, and it never exceeds the FIFO's free slots.
- R4: The request address equals base + fetch pointer × stride. The stride is field [29:16] of the descriptor-format word (address 2).
- R5: At most one fetch is outstanding. A request holds its valid, address and length unchanged until it is accepted.
- R6: When the last beat of a fetch arrives, the fetch pointer (readable at address 6) advances by the fetch length. It returns to 0 on reaching the ring length.
- R7: Descriptors leave the output in ring order. Each output handshake adds one to the processed count (address 5) and advances the processed pointer (address 7), which wraps at the ring length.
- R8: Writing a value to address 4 adds its low 16 bits to the announced count. Reading address 4 returns the announced total.
- R9: Writing address 8 clears state according to the bits set: bit 0 clears the announced and fetched totals, bit 1 the processed count, bit 2 the fetch pointer, and bit 3 the processed pointer.
- R10: The status word at address 9 holds five flags. Bit 0 is a fetch completed. Bit 1 is an announcement that left more than the ring length waiting. Bit 2 is that every announced descriptor has been processed. Bit 3 is a response beat with no fetch outstanding; such a beat is otherwise ignored. Bit 4 is a write of the fetch-control word while a fetch is outstanding. Writing ones clears flags, but a new event in the same cycle takes priority over the clear.
- R11: Reads return data one cycle after the read strobe. Address 0 is the base. The descriptor-format word reads back bits [30:0] as written: descriptor size in [15:0], stride in [29:16], extra-token flag in bit 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| dma_req_valid | output | 1 | Burst read request pending |
| dma_req_ready | input | 1 | Request accepted by the DMA master |
| dma_req_addr | output | ADDR_W | Byte address of the first descriptor |
| dma_req_len | output | 16 | Number of descriptors in the burst |
| dma_rsp_valid | input | 1 | One descriptor beat returned |
| dma_rsp_data | input | DESC_W | Returned descriptor beat |
| out_valid | output | 1 | Descriptor available for the parser |
| out_ready | input | 1 | Parser takes the descriptor |
| out_data | output | DESC_W | Head descriptor of the FIFO |

## Verification
The bench builds a ring whose fetches run into the ring end, so the burst length must be clipped there and the pointer must wrap to zero. A design that ignored the clip would read past the ring, and one with a bad wrap would address the wrong descriptor on the next fetch. The bench also holds the FIFO just below the free-slot threshold to show that no request appears until one descriptor drains. A design that compared against the burst length alone would fetch too early. Other cases are a request kept waiting for acceptance (its address and length must not drift), the status flags for a stray response beat and for a fetch-control write during a burst, and the two wrapping counters after a full drain. A design that lets a stray beat into the FIFO would show a valid output with nothing fetched.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  // register field width for counts, lengths and ring indices
  localparam int FLD_W = 16;
  localparam int STR_W = 14;
  localparam int NSTAT = 5;

  typedef enum logic [3:0] {
    RA_BASE  = 4'd0,
    RA_RSIZE = 4'd1,
    RA_DFMT  = 4'd2,
    RA_FCTL  = 4'd3,
    RA_ANN   = 4'd4,
    RA_PROC  = 4'd5,
    RA_FPTR  = 4'd6,
    RA_PPTR  = 4'd7,
    RA_CLR   = 4'd8,
    RA_STAT  = 4'd9
  } reg_addr_e;

  typedef enum logic [1:0] {
    FE_IDLE = 2'd0,
    FE_REQ  = 2'd1,
    FE_DATA = 2'd2
  } fe_state_e;

  // status flag positions
  localparam int ST_DONE  = 0;
  localparam int ST_OVF   = 1;
  localparam int ST_DRAIN = 2;
  localparam int ST_STRAY = 3;
  localparam int ST_BUSYW = 4;
endpackage

// File: rtl/cdr_desc_fifo.sv
module cdr_desc_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> ((count < CW'(DEPTH)) || pop));
endmodule

// File: rtl/cdr_fetch_engine.sv
module cdr_fetch_engine
  import cdr_pkg::*;
#(
  parameter int AW  = 32,
  parameter int FCW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_en,
  input  logic [FLD_W-1:0] fsize,
  input  logic [FLD_W-1:0] fthresh,
  input  logic [FLD_W-1:0] rsize,
  input  logic [AW-1:0]    base,
  input  logic [STR_W-1:0] stride,
  input  logic [FLD_W-1:0] pending,
  input  logic [FCW-1:0]   fifo_free,
  input  logic             ptr_clr,
  input  logic             dma_req_ready,
  input  logic             dma_rsp_valid,
  output logic             dma_req_valid,
  output logic [AW-1:0]    dma_req_addr,
  output logic [FLD_W-1:0] dma_req_len,
  output logic             beat_push,
  output logic             done,
  output logic [FLD_W-1:0] fptr,
  output logic             stray,
  output logic             busy
);
  fe_state_e        state;
  logic [FLD_W-1:0] beats;
  logic [FLD_W-1:0] room, cand, free_x;
  logic [FLD_W:0]   nxt;
  logic             go;

  always_comb begin
    free_x = FLD_W'(fifo_free);
    room   = rsize - fptr;
    cand   = fsize;
    if (pending < cand) cand = pending;
    if (room < cand)    cand = room;
    go = fetch_en && (rsize != '0) && (fptr < rsize) && (pending != '0) &&
         (free_x >= fthresh) && (free_x >= cand) && (cand != '0);
  end

  assign dma_req_valid = (state == FE_REQ);
  assign busy          = (state != FE_IDLE);
  assign beat_push     = (state == FE_DATA) && dma_rsp_valid;
  assign stray         = dma_rsp_valid && (state != FE_DATA);
  assign done          = beat_push && (beats == dma_req_len - FLD_W'(1));
  assign nxt           = {1'b0, fptr} + {1'b0, dma_req_len};

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= FE_IDLE;
      beats        <= '0;
      dma_req_addr <= '0;
      dma_req_len  <= '0;
    end else begin
      case (state)
        FE_IDLE: if (go) begin
          dma_req_len  <= cand;
          dma_req_addr <= base + AW'(fptr) * AW'(stride);
          state        <= FE_REQ;
        end
        FE_REQ: if (dma_req_ready) begin
          beats <= '0;
          state <= FE_DATA;
        end
        FE_DATA: if (dma_rsp_valid) begin
          beats <= beats + FLD_W'(1);
          if (done) state <= FE_IDLE;
        end
        default: state <= FE_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ptr_clr)  fptr <= '0;
    else if (done)       fptr <= (nxt >= {1'b0, rsize}) ? FLD_W'(nxt - {1'b0, rsize})
                                                        : FLD_W'(nxt);
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_req_valid && !dma_req_ready) |=>
      (dma_req_valid && $stable(dma_req_addr) && $stable(dma_req_len)));
  // R3
  req_len_nz_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req_valid |-> (dma_req_len != '0));
  // R6
  fptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !ptr_clr && rsize != '0) |=> (fptr < $past(rsize)));
endmodule

// File: rtl/cdr_fetcher.sv
module cdr_fetcher
  import cdr_pkg::*;
#(
  parameter int DESC_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int ADDR_W     = 32,
  localparam int FCW       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              dma_req_valid,
  input  logic              dma_req_ready,
  output logic [ADDR_W-1:0] dma_req_addr,
  output logic [15:0]       dma_req_len,
  input  logic              dma_rsp_valid,
  input  logic [DESC_W-1:0] dma_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DESC_W-1:0] out_data
);
  logic [ADDR_W-1:0] base_q;
  logic [FLD_W-1:0]  rsize_q, ann_cnt, fet_cnt, proc_cnt, pptr, fptr, pending;
  logic [30:0]       dfmt_q;
  logic [31:0]       fctl_q;
  logic [NSTAT-1:0]  stat_q, stat_set;
  logic [FCW-1:0]    fcount, ffree;
  logic              pop, beat_push, done, stray, busy, fetch_en;
  logic              wr_ann, wr_clr, wr_fctl, wr_stat;
  logic [FLD_W-1:0]  delta;
  reg_addr_e         ra;

  assign ra       = reg_addr_e'(reg_addr);
  assign wr_ann   = reg_wr && (ra == RA_ANN);
  assign wr_clr   = reg_wr && (ra == RA_CLR);
  assign wr_fctl  = reg_wr && (ra == RA_FCTL);
  assign wr_stat  = reg_wr && (ra == RA_STAT);
  assign delta    = reg_wdata[FLD_W-1:0];
  assign pending  = ann_cnt - fet_cnt;
  assign fetch_en = (fctl_q != '0) && (fctl_q[FLD_W-1:0] != '0);
  assign pop      = out_valid && out_ready;
  assign ffree    = FCW'(FIFO_DEPTH) - fcount;

  cdr_fetch_engine #(.AW(ADDR_W), .FCW(FCW)) u_eng (
    .clk           (clk),
    .rst           (rst),
    .fetch_en      (fetch_en),
    .fsize         (fctl_q[FLD_W-1:0]),
    .fthresh       (fctl_q[31:16]),
    .rsize         (rsize_q),
    .base          (base_q),
    .stride        (dfmt_q[16 +: STR_W]),
    .pending       (pending),
    .fifo_free     (ffree),
    .ptr_clr       (wr_clr && reg_wdata[2]),
    .dma_req_ready (dma_req_ready),
    .dma_rsp_valid (dma_rsp_valid),
    .dma_req_valid (dma_req_valid),
    .dma_req_addr  (dma_req_addr),
    .dma_req_len   (dma_req_len),
    .beat_push     (beat_push),
    .done          (done),
    .fptr          (fptr),
    .stray         (stray),
    .busy          (busy)
  );

  cdr_desc_fifo #(.W(DESC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (beat_push),
    .push_data (dma_rsp_data),
    .pop       (pop),
    .out_valid (out_valid),
    .out_data  (out_data),
    .count     (fcount)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      rsize_q <= '0;
      dfmt_q  <= '0;
      fctl_q  <= '0;
    end else if (reg_wr) begin
      case (ra)
        RA_BASE:  base_q  <= reg_wdata[ADDR_W-1:0];
        RA_RSIZE: rsize_q <= reg_wdata[FLD_W-1:0];
        RA_DFMT:  dfmt_q  <= reg_wdata[30:0];
        RA_FCTL:  fctl_q  <= reg_wdata;
        default:  ;
      endcase
    end
  end

  // running totals and processed pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      ann_cnt  <= '0;
      fet_cnt  <= '0;
      proc_cnt <= '0;
      pptr     <= '0;
    end else begin
      if (wr_clr && reg_wdata[0]) begin
        ann_cnt <= '0;
        fet_cnt <= '0;
      end else begin
        if (wr_ann) ann_cnt <= ann_cnt + delta;
        if (done)   fet_cnt <= fet_cnt + dma_req_len;
      end
      if (wr_clr && reg_wdata[1]) proc_cnt <= '0;
      else if (pop)               proc_cnt <= proc_cnt + FLD_W'(1);
      if (wr_clr && reg_wdata[3]) pptr <= '0;
      else if (pop)               pptr <= (pptr + FLD_W'(1) >= rsize_q) ? '0 : pptr + FLD_W'(1);
    end
  end

  // status flags: set wins over write-one-to-clear
  always_comb begin
    stat_set           = '0;
    stat_set[ST_DONE]  = done;
    stat_set[ST_OVF]   = wr_ann && ({1'b0, pending} + {1'b0, delta} > {1'b0, rsize_q});
    stat_set[ST_DRAIN] = pop && (proc_cnt + FLD_W'(1) == ann_cnt);
    stat_set[ST_STRAY] = stray;
    stat_set[ST_BUSYW] = wr_fctl && busy;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~(wr_stat ? reg_wdata[NSTAT-1:0] : '0)) | stat_set;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      case (ra)
        RA_BASE:  reg_rdata <= 32'(base_q);
        RA_RSIZE: reg_rdata <= 32'(rsize_q);
        RA_DFMT:  reg_rdata <= {1'b0, dfmt_q};
        RA_FCTL:  reg_rdata <= fctl_q;
        RA_ANN:   reg_rdata <= 32'(ann_cnt);
        RA_PROC:  reg_rdata <= 32'(proc_cnt);
        RA_FPTR:  reg_rdata <= 32'(fptr);
        RA_PPTR:  reg_rdata <= 32'(pptr);
        RA_STAT:  reg_rdata <= 32'(stat_q);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  // R3
  req_fits_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req_valid |-> (dma_req_len <= FLD_W'(ffree)));
  // R7
  proc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pop && !(wr_clr && reg_wdata[1])) |=> $stable(proc_cnt));
  // R10
  stray_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    stray |-> !beat_push);
endmodule

// File: tb/cdr_fetcher_tb.sv
module cdr_fetcher_tb;
  localparam logic [31:0] BASE   = 32'h1000_0000;
  localparam int          STRIDE = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        dma_req_valid, dma_req_ready = 0;
  logic [31:0] dma_req_addr;
  logic [15:0] dma_req_len;
  logic        dma_rsp_valid = 0;
  logic [31:0] dma_rsp_data = 0;
  logic        out_valid, out_ready = 0;
  logic [31:0] out_data;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  cdr_fetcher u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req_valid(dma_req_valid),
    .dma_req_ready(dma_req_ready), .dma_req_addr(dma_req_addr), .dma_req_len(dma_req_len),
    .dma_rsp_valid(dma_rsp_valid), .dma_rsp_data(dma_rsp_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [31:0] pat(input int idx);
    return 32'hA500_0000 | 32'(idx);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic serve(input logic [31:0] ea, input int el, input int hold, input string tag);
    int n = 0;
    int idx;
    while (!dma_req_valid && n < 50) begin @(negedge clk); n++; end
    chk({tag, " req valid"}, 32'(dma_req_valid), 1);
    chk({tag, " addr R4"}, dma_req_addr, ea);
    chk({tag, " len R3"}, 32'(dma_req_len), 32'(el));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk({tag, " held R5"}, {dma_req_valid, dma_req_addr[30:0]}, {1'b1, ea[30:0]});
    end
    dma_req_ready = 1;
    @(negedge clk);
    dma_req_ready = 0;
    idx = int'((ea - BASE) / STRIDE);
    for (int k = 0; k < el; k++) begin
      dma_rsp_valid = 1; dma_rsp_data = pat(idx + k);
      @(negedge clk);
    end
    dma_rsp_valid = 0;
  endtask

  task automatic pop_chk(input int idx, input string tag);
    chk({tag, " out_valid R7"}, 32'(out_valid), 1);
    chk({tag, " data R7"}, out_data, pat(idx));
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic idle_chk(input int cyc, input string tag);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (dma_req_valid) seen++;
    end
    chk(tag, 32'(seen), 0);
  endtask

  task automatic t_reset;
    chk("R1 req idle", 32'(dma_req_valid), 0);
    chk("R1 out empty", 32'(out_valid), 0);
    rd_chk(4'd4, 0, "R1 announced");
    rd_chk(4'd6, 0, "R1 fptr");
    rd_chk(4'd9, 0, "R1 status");
  endtask

  task automatic t_config;
    wr(4'd0, BASE);
    wr(4'd1, 32'd8);
    wr(4'd2, 32'h4020_0008);
    rd_chk(4'd2, 32'h4020_0008, "R11 descriptor format");
    rd_chk(4'd0, BASE, "R11 base");
    wr(4'd4, 32'd3);
    rd_chk(4'd4, 32'd3, "R8 announced");
    idle_chk(10, "R2 disabled no fetch");
    wr(4'd3, 32'h0000_0000 | 32'h0001_0000);
    idle_chk(6, "R2 size field zero no fetch");
  endtask

  task automatic t_basic;
    wr(4'd3, 32'h0001_0002);
    serve(BASE, 2, 3, "R3 first block");
    serve(BASE + 32'd64, 1, 0, "R3 partial block");
    rd_chk(4'd6, 32'd3, "R6 fptr after two");
    for (int i = 0; i < 3; i++) pop_chk(i, "R7 basic");
    rd_chk(4'd5, 32'd3, "R7 processed count");
    rd_chk(4'd7, 32'd3, "R7 processed ptr");
    rd_chk(4'd9, 32'h5, "R10 done and drained");
  endtask

  task automatic t_wrap;
    wr(4'd4, 32'd6);
    serve(BASE + 32'd96, 2, 0, "R6 wrap a");
    serve(BASE + 32'd160, 2, 0, "R6 wrap b");
    serve(BASE + 32'd224, 1, 0, "R3 clip at ring end");
    serve(BASE, 1, 0, "R6 after wrap");
    rd_chk(4'd6, 32'd1, "R6 fptr wrapped");
  endtask

  task automatic t_thresh;
    wr(4'd3, 32'h0003_0002);
    wr(4'd4, 32'd2);
    idle_chk(8, "R3 below threshold");
    pop_chk(3, "R3 drain one");
    serve(BASE + 32'd32, 2, 0, "R3 threshold met");
    for (int i = 4; i < 11; i++) pop_chk(i % 8, "R7 drain");
    chk("R7 empty", 32'(out_valid), 0);
    rd_chk(4'd5, 32'd11, "R7 processed total");
    rd_chk(4'd7, 32'd3, "R7 processed ptr wrapped");
  endtask

  task automatic t_clear;
    wr(4'd3, 32'd0);
    wr(4'd8, 32'hF);
    rd_chk(4'd4, 0, "R9 announced cleared");
    rd_chk(4'd5, 0, "R9 processed cleared");
    rd_chk(4'd6, 0, "R9 fptr cleared");
    rd_chk(4'd7, 0, "R9 pptr cleared");
    wr(4'd9, 32'h1F);
    rd_chk(4'd9, 0, "R10 write one clear");
    wr(4'd4, 32'd9);
    rd_chk(4'd9, 32'h2, "R10 announce overflow");
    wr(4'd8, 32'h1);
    wr(4'd9, 32'h1F);
  endtask

  task automatic t_flags;
    wr(4'd3, 32'h0001_0002);
    wr(4'd4, 32'd1);
    while (!dma_req_valid) @(negedge clk);
    wr(4'd3, 32'h0001_0002);
    serve(BASE, 1, 0, "R5 request after config write");
    pop_chk(0, "R7 flag case");
    dma_rsp_valid = 1; dma_rsp_data = 32'hDEAD_BEEF;
    @(negedge clk);
    dma_rsp_valid = 0;
    @(negedge clk);
    chk("R10 stray beat ignored", 32'(out_valid), 0);
    rd_chk(4'd9, 32'h1D, "R10 stray and busy write flags");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_config;
    t_basic;
    t_wrap;
    t_thresh;
    t_clear;
    t_flags;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule